// File: doc/BRIEF.md
# CEC Frame Transmitter

This block puts one consumer-electronics-control frame onto a shared single-wire bus. The pin is open drain, so the block only ever pulls the line low or lets it go. A frame opens with a long start symbol. A header block follows, then as many data blocks as software supplies. Every block carries eight data bits, most significant bit first, then an end-of-message (EOM) bit, then an acknowledge slot. Each bit is coded as a low pulse of a given length inside a fixed bit period. All lengths are counted in ticks of a prescaled count source.

Software drives the block in a fixed way. It places a byte in a one-deep transmit buffer and pulses `tx_start`. After that it refills the buffer each time `buf_empty` rises. The block copies the buffer into its shift register when a block begins. In automatic EOM mode the EOM bit is 1 exactly when no next byte is waiting in the buffer. In manual mode the EOM bit comes from a flag that is written together with each byte.

Two events are marked in every block: the end of the last data bit and the end of the acknowledge slot. Each event sets a sticky flag, and each can raise an interrupt pulse if its enable is set. During the acknowledge slot the block drives a logical 1 and then samples the line. A follower that holds the line low at the sample point has acknowledged the block.

Top module: `cec_tx`

## Requirements
- R1: A frame goes out as one start symbol, then blocks. Each block is 8 data bits from bit 7 down to bit 0, then the EOM bit, then an acknowledge slot. The header is the first byte loaded.
- R2: Symbol timing in ticks is as follows. The start symbol is low for START_LOW with a period of START_PER. A 0 is low for ZERO_LOW and a 1 is low for ONE_LOW, both with a period of BIT_PER. In the acknowledge slot the block drives a 1.
- R3: The line is never pulled low while `tx_en` is 0. After `tx_start`, the start symbol begins on the first clock edge where `tick` is 1.
- R4: When `auto_eom`=1, the EOM bit is 1 if and only if the buffer is empty when bit 0 of the block ends. When `auto_eom`=0, the EOM bit equals the `buf_eom` value written with that byte.
- R5: `buf_empty` reads 1 after reset and again whenever a byte moves into the shift register. A write is accepted only while `buf_empty`=1. A write at any other time is ignored.
- R6: `flag8` is set when bit 0 of a block ends. `irq` pulses for one cycle at that point when `int8_en`=1.
- R7: `flag_tx` is set when the acknowledge slot of a block ends. `irq` pulses for one cycle at that point when `int10_en`=1.
- R8: A pulse on `flag8_clr` clears `flag8`, and a pulse on `flagtx_clr` clears `flag_tx`. If a set and a clear arrive in the same cycle, the set wins.
- R9: `ack_seen` takes the line level at tick ACK_SMP of the acknowledge slot. A line held low there gives 1, and a line that has been released gives 0.
- R10: `tx_en` clears itself at the end of the acknowledge slot of a block whose EOM bit was 1. It also clears when a block boundary is reached and no byte is waiting in the buffer. In both cases the frame ends there.
- R11: After reset, `cec_drive_low`, `tx_en`, `flag8`, `flag_tx`, `ack_seen` and `irq` are all 0, and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescaled count-source pulse, one bit-timing unit |
| tx_start | input | 1 | Pulse that sets the transmit enable |
| auto_eom | input | 1 | 1: EOM bit from the buffer state; 0: EOM bit from `buf_eom` |
| int8_en | input | 1 | Interrupt enable for the end of bit 0 |
| int10_en | input | 1 | Interrupt enable for the end of the acknowledge slot |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_data | input | 8 | Byte to write into the buffer |
| buf_eom | input | 1 | EOM value stored with the byte (manual mode) |
| flag8_clr | input | 1 | Clears `flag8` |
| flagtx_clr | input | 1 | Clears `flag_tx` |
| cec_in | input | 1 | Bus line level as read back |
| cec_drive_low | output | 1 | 1 pulls the open-drain line low |
| tx_en | output | 1 | A frame is pending or in progress |
| buf_empty | output | 1 | The buffer may be written |
| flag8 | output | 1 | Sticky end-of-bit-0 flag |
| flag_tx | output | 1 | Sticky end-of-block flag |
| ack_seen | output | 1 | Acknowledge level sampled in the last acknowledge slot |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The scoreboard decodes every low pulse on the line and checks both its length and its spacing. Several frames exercise the main function:
- A two-byte frame in automatic EOM mode, with every block acknowledged. This shows whether the EOM bit follows the buffer state.
- A one-byte frame that no follower acknowledges, sent after an ignored second write. This separates a held buffer from an overwritten one and shows a 0 sample in the acknowledge slot.
- A three-byte frame in manual EOM mode with mixed acknowledges, including the patterns 0x00 and 0xFF. This tells the value-driven EOM apart from the buffer-driven one.
- A manual frame whose only byte carries an EOM of 0. This exercises the underrun ending.

In the first frame `tick` is held low after the start request, which shows that the block waits for the count source.

// File: rtl/cec_tx_pkg.sv
// Package: shared types and block-layout constants of the frame transmitter.
package cec_tx_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned IDX_W   = 4;
    // Position of each slot within a block (order is behaviour)
    localparam logic [IDX_W-1:0] IDX_LAST_DATA = 4'd7;
    localparam logic [IDX_W-1:0] IDX_EOM       = 4'd8;
    localparam logic [IDX_W-1:0] IDX_ACK       = 4'd9;

    // Symbol shape the bit generator produces
    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_ZERO  = 2'd1,
        SYM_ONE   = 2'd2
    } sym_e;

    // Frame sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2
    } seq_e;

endpackage

// File: rtl/cec_tx_bitgen.sv
// Module: cec_tx_bitgen
// Shapes one symbol at a time: it counts ticks inside the current symbol,
// pulls the line low for the symbol's low time and flags the symbol's last
// tick. Assumes the symbol kind stays stable for the whole symbol and that
// every low time is shorter than its period.
module cec_tx_bitgen
    import cec_tx_pkg::*;
#(
    parameter int unsigned START_LOW = 74,
    parameter int unsigned START_PER = 90,
    parameter int unsigned ZERO_LOW  = 30,
    parameter int unsigned ONE_LOW   = 12,
    parameter int unsigned BIT_PER   = 48,
    parameter int unsigned ACK_SMP   = 21,
    parameter int unsigned CNT_W     = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  sym_e sym,
    output logic drive_low,
    output logic sym_end,
    output logic smp_pt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] per_len;

    // Purpose: pick the low time and the period of the current symbol.
    always_comb begin
        unique case (sym)
            SYM_START: begin
                low_len = CNT_W'(START_LOW);
                per_len = CNT_W'(START_PER);
            end
            SYM_ZERO: begin
                low_len = CNT_W'(ZERO_LOW);
                per_len = CNT_W'(BIT_PER);
            end
            default: begin
                low_len = CNT_W'(ONE_LOW);
                per_len = CNT_W'(BIT_PER);
            end
        endcase
    end

    assign sym_end   = active && tick && (cnt_q == per_len - 1'b1);
    assign drive_low = active && (cnt_q < low_len);
    assign smp_pt    = active && tick && (cnt_q == CNT_W'(ACK_SMP));

    // Purpose: tick counter inside a symbol, restarting at each symbol end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= sym_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cec_tx_buf.sv
// Module: cec_tx_buf
// One-deep transmit buffer holding a byte and its EOM flag. A write is
// taken only while the buffer is empty, and a take by the sequencer empties
// it. Assumes take is only asserted while the buffer is full.
module cec_tx_buf
    import cec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              weom,
    input  logic              take,
    output logic              empty,
    output logic [BYTE_W-1:0] byte_q,
    output logic              eom_q
);

    // Purpose: accept writes only in the empty window; empty on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty  <= 1'b1;
            byte_q <= '0;
            eom_q  <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end else if (wr && empty) begin
            empty  <= 1'b0;
            byte_q <= wdata;
            eom_q  <= weom;
        end
    end

endmodule

// File: rtl/cec_tx_seq.sv
// Module: cec_tx_seq
// Frame sequencer: owns the transmit enable, waits for the first tick,
// steps through start symbol, data bits, EOM and acknowledge slot, loads
// bytes from the buffer and decides the EOM value. Assumes sym_end comes
// from the bit generator driven by this module's sym output.
module cec_tx_seq
    import cec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_start,
    input  logic              auto_eom,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_byte,
    input  logic              buf_eom,
    input  logic              sym_end,
    output logic              active,
    output sym_e              sym,
    output logic              take,
    output logic              ev_d0,
    output logic              ev_blk,
    output logic              in_ack,
    output logic              tx_en,
    output logic [IDX_W-1:0]  bit_idx
);

    seq_e              st_q;
    logic [BYTE_W-1:0] sh_q;
    logic              cur_eom_q;
    logic              eom_bit_q;
    logic              at_start_end;
    logic              at_blk_end;

    assign active       = (st_q != ST_IDLE);
    assign at_start_end = sym_end && (st_q == ST_START);
    assign at_blk_end   = sym_end && (st_q == ST_BITS) && (bit_idx == IDX_ACK);
    assign ev_d0        = sym_end && (st_q == ST_BITS) && (bit_idx == IDX_LAST_DATA);
    assign ev_blk       = at_blk_end;
    assign in_ack       = (st_q == ST_BITS) && (bit_idx == IDX_ACK);
    assign take         = buf_full && (at_start_end || (at_blk_end && !eom_bit_q));

    // Purpose: select the symbol shape for the current slot.
    always_comb begin
        if (st_q == ST_START) begin
            sym = SYM_START;
        end else if (bit_idx < IDX_EOM) begin
            sym = sh_q[BYTE_W-1] ? SYM_ONE : SYM_ZERO;
        end else if (bit_idx == IDX_EOM) begin
            sym = eom_bit_q ? SYM_ONE : SYM_ZERO;
        end else begin
            sym = SYM_ONE;
        end
    end

    // Purpose: frame state, slot index, shift register and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            tx_en     <= 1'b0;
            bit_idx   <= '0;
            sh_q      <= '0;
            cur_eom_q <= 1'b0;
            eom_bit_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (tx_start) begin
                        tx_en <= 1'b1;
                    end
                    if (tx_en && tick) begin
                        st_q <= ST_START;
                    end
                end
                ST_START: begin
                    if (at_start_end) begin
                        if (buf_full) begin
                            st_q      <= ST_BITS;
                            bit_idx   <= '0;
                            sh_q      <= buf_byte;
                            cur_eom_q <= buf_eom;
                        end else begin
                            st_q  <= ST_IDLE;
                            tx_en <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (sym_end) begin
                        if (bit_idx < IDX_LAST_DATA) begin
                            sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                        end else if (bit_idx == IDX_LAST_DATA) begin
                            eom_bit_q <= auto_eom ? !buf_full : cur_eom_q;
                            bit_idx   <= IDX_EOM;
                        end else if (bit_idx == IDX_EOM) begin
                            bit_idx <= IDX_ACK;
                        end else if (!eom_bit_q && buf_full) begin
                            bit_idx   <= '0;
                            sh_q      <= buf_byte;
                            cur_eom_q <= buf_eom;
                        end else begin
                            st_q    <= ST_IDLE;
                            tx_en   <= 1'b0;
                            bit_idx <= '0;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cec_tx_status.sv
// Module: cec_tx_status
// Sticky event flags, the interrupt pulse and the acknowledge sample.
// The bus read-back is synchronised over SYNC_STAGES flops before it is
// sampled. Assumes event strobes last one cycle.
module cec_tx_status #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_d0,
    input  logic ev_blk,
    input  logic smp_ack,
    input  logic cec_in,
    input  logic int8_en,
    input  logic int10_en,
    input  logic flag8_clr,
    input  logic flagtx_clr,
    output logic flag8,
    output logic flag_tx,
    output logic irq,
    output logic ack_seen
);

    logic line_s;

    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic s_q;
            // Purpose: single-flop capture of the bus level.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= cec_in;
            end
            assign line_s = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            // Purpose: multi-flop synchroniser for the bus level.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= {s_q[SYNC_STAGES-2:0], cec_in};
            end
            assign line_s = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: sticky flags with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag8   <= 1'b0;
            flag_tx <= 1'b0;
        end else begin
            if (ev_d0)          flag8 <= 1'b1;
            else if (flag8_clr) flag8 <= 1'b0;
            if (ev_blk)          flag_tx <= 1'b1;
            else if (flagtx_clr) flag_tx <= 1'b0;
        end
    end

    // Purpose: one-cycle interrupt pulse on enabled events.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (ev_d0 && int8_en) || (ev_blk && int10_en);
    end

    // Purpose: store the acknowledge level at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_seen <= 1'b0;
        else if (smp_ack) ack_seen <= !line_s;
    end

endmodule

// File: rtl/cec_tx.sv
// Module: cec_tx (top)
// Frame transmitter for the single-wire control bus: buffer, sequencer,
// symbol generator and status. Assumes tick is a one-cycle pulse per
// timing unit and cec_in reflects the open-drain line.
module cec_tx
    import cec_tx_pkg::*;
#(
    parameter int unsigned START_LOW   = 74,
    parameter int unsigned START_PER   = 90,
    parameter int unsigned ZERO_LOW    = 30,
    parameter int unsigned ONE_LOW     = 12,
    parameter int unsigned BIT_PER     = 48,
    parameter int unsigned ACK_SMP     = 21,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       tx_start,
    input  logic       auto_eom,
    input  logic       int8_en,
    input  logic       int10_en,
    input  logic       buf_wr,
    input  logic [7:0] buf_data,
    input  logic       buf_eom,
    input  logic       flag8_clr,
    input  logic       flagtx_clr,
    input  logic       cec_in,
    output logic       cec_drive_low,
    output logic       tx_en,
    output logic       buf_empty,
    output logic       flag8,
    output logic       flag_tx,
    output logic       ack_seen,
    output logic       irq
);

    localparam int unsigned CNT_W = $clog2(START_PER + 1);

    logic              active;
    sym_e              sym;
    logic              sym_end;
    logic              smp_pt;
    logic              take;
    logic              ev_d0;
    logic              ev_blk;
    logic              in_ack;
    logic [BYTE_W-1:0] buf_byte;
    logic              buf_eom_q;
    logic [IDX_W-1:0]  bit_idx;
    logic              smp_ack;

    assign smp_ack = smp_pt && in_ack;

    cec_tx_buf u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (buf_wr),
        .wdata  (buf_data),
        .weom   (buf_eom),
        .take   (take),
        .empty  (buf_empty),
        .byte_q (buf_byte),
        .eom_q  (buf_eom_q)
    );

    cec_tx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tx_start (tx_start),
        .auto_eom (auto_eom),
        .buf_full (!buf_empty),
        .buf_byte (buf_byte),
        .buf_eom  (buf_eom_q),
        .sym_end  (sym_end),
        .active   (active),
        .sym      (sym),
        .take     (take),
        .ev_d0    (ev_d0),
        .ev_blk   (ev_blk),
        .in_ack   (in_ack),
        .tx_en    (tx_en),
        .bit_idx  (bit_idx)
    );

    cec_tx_bitgen #(
        .START_LOW (START_LOW),
        .START_PER (START_PER),
        .ZERO_LOW  (ZERO_LOW),
        .ONE_LOW   (ONE_LOW),
        .BIT_PER   (BIT_PER),
        .ACK_SMP   (ACK_SMP),
        .CNT_W     (CNT_W)
    ) u_bitgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .active    (active),
        .sym       (sym),
        .drive_low (cec_drive_low),
        .sym_end   (sym_end),
        .smp_pt    (smp_pt)
    );

    cec_tx_status #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_d0      (ev_d0),
        .ev_blk     (ev_blk),
        .smp_ack    (smp_ack),
        .cec_in     (cec_in),
        .int8_en    (int8_en),
        .int10_en   (int10_en),
        .flag8_clr  (flag8_clr),
        .flagtx_clr (flagtx_clr),
        .flag8      (flag8),
        .flag_tx    (flag_tx),
        .irq        (irq),
        .ack_seen   (ack_seen)
    );

endmodule

// File: rtl/cec_tx_chk.sv
// Module: cec_tx_chk
// Property checker bound to cec_tx. It watches the ports and the internal
// hand-offs between buffer, sequencer and status logic.
module cec_tx_chk #(
    parameter int unsigned START_LOW = 74
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       cec_drive_low,
    input logic       tx_en,
    input logic       buf_wr,
    input logic       buf_empty,
    input logic [7:0] buf_byte,
    input logic       take,
    input logic       smp_ack,
    input logic       ack_seen,
    input logic       irq,
    input logic       flag8,
    input logic       flag_tx,
    input logic [3:0] bit_idx
);

    logic [15:0] low_run;

    // Purpose: count ticks while the line is held low.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (!cec_drive_low) low_run <= '0;
        else if (tick)           low_run <= low_run + 1'b1;
    end

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !cec_drive_low);

    p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 16'(START_LOW));

    p_full_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && !buf_empty && !take) |=> $stable(buf_byte));

    p_empty_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(take));

    p_ack_at_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_seen) |-> $past(smp_ack));

    p_irq_has_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag8 || flag_tx));

    p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= 4'd9);

endmodule

bind cec_tx cec_tx_chk #(.START_LOW(START_LOW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .cec_drive_low (cec_drive_low),
    .tx_en         (tx_en),
    .buf_wr        (buf_wr),
    .buf_empty     (buf_empty),
    .buf_byte      (buf_byte),
    .take          (take),
    .smp_ack       (smp_ack),
    .ack_seen      (ack_seen),
    .irq           (irq),
    .flag8         (flag8),
    .flag_tx       (flag_tx),
    .bit_idx       (bit_idx)
);

// File: tb/cec_tx_bench.sv
// Scoreboard bench: the frame driver queues the expected symbols; a monitor
// decodes low pulses on the line and compares them in order.
module cec_tx_bench;

    localparam int SL = 74, SP = 90, ZL = 30, OL = 12, BP = 48;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, tx_start = 1'b0;
    logic auto_eom = 1'b0, int8_en = 1'b0, int10_en = 1'b0;
    logic buf_wr = 1'b0, buf_eom = 1'b0, flag8_clr = 1'b0, flagtx_clr = 1'b0;
    logic [7:0] buf_data = '0;
    logic ext_low = 1'b0;
    logic cec_in, cec_drive_low, tx_en, buf_empty, flag8, flag_tx, ack_seen, irq;

    assign cec_in = !(cec_drive_low || ext_low);

    always #2 clk = !clk;   // 250 MHz

    cec_tx u_cec_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_start(tx_start),
        .auto_eom(auto_eom), .int8_en(int8_en), .int10_en(int10_en),
        .buf_wr(buf_wr), .buf_data(buf_data), .buf_eom(buf_eom),
        .flag8_clr(flag8_clr), .flagtx_clr(flagtx_clr), .cec_in(cec_in),
        .cec_drive_low(cec_drive_low), .tx_en(tx_en), .buf_empty(buf_empty),
        .flag8(flag8), .flag_tx(flag_tx), .ack_seen(ack_seen), .irq(irq)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, irq_cnt = 0;
    int exp_q[$];
    bit ack_plan[8];
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: decode symbols, act as acknowledging follower, count irqs.
    initial begin
        int rise_t = 0, prev_rise = -1, prev_kind = -1, bits = 0, ack_cd = 0;
        bit in_frame = 1'b0, prev_low = 1'b0;
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
            if (ack_cd > 0) begin
                ack_cd--;
                if (ack_cd == 0) ext_low = 1'b0;
            end
            if (cec_drive_low && !prev_low) begin
                if (prev_rise >= 0 && cyc - prev_rise < 400 && prev_kind >= 0)
                    chk(cyc - prev_rise == (prev_kind == 2 ? SP : BP), "R2 period",
                        cyc - prev_rise, prev_kind == 2 ? SP : BP);
                if (cyc - prev_rise >= 400) in_frame = 1'b0;
                if (in_frame && (bits % 10) == 9 && ack_plan[(bits / 10) % 8]) begin
                    ext_low = 1'b1;
                    ack_cd  = ZL;
                end
                prev_rise = cyc;
                rise_t    = cyc;
            end
            if (!cec_drive_low && prev_low) begin
                int dur, kind, e;
                dur  = cyc - rise_t;
                kind = (dur == SL) ? 2 : (dur == OL) ? 1 : (dur == ZL) ? 0 : -1;
                chk(kind >= 0, "R2 low time", dur, -1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected symbol", kind, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(kind == e, "R1 symbol", kind, e);
                end
                if (kind == 2) begin
                    in_frame = 1'b1;
                    bits     = 0;
                end else begin
                    bits++;
                end
                prev_kind = kind;
            end
            prev_low = cec_drive_low;
        end
    end

    task automatic wr_buf(input logic [7:0] d, input bit e);
        @(negedge clk);
        buf_wr = 1'b1; buf_data = d; buf_eom = e;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    // Driver: queue expected symbols, feed the buffer, then check status.
    task automatic run_frame(input logic [7:0] fb[8], input int n, input bit am,
                             input bit last_eom, input bit e8, input bit e10,
                             input bit hold_tick, input bit overwrite);
        int guard;
        exp_q.push_back(2);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) exp_q.push_back(int'(fb[i][b]));
            exp_q.push_back((i == n - 1) ? int'(last_eom) : 0);
            exp_q.push_back(1);
        end
        auto_eom = am; int8_en = e8; int10_en = e10; irq_cnt = 0;
        wr_buf(fb[0], !am && n == 1 && last_eom);
        if (overwrite) begin
            wr_buf(8'hFF, 1'b1);   // buffer full: must be ignored (R5)
            chk(buf_empty == 1'b0, "R5 buffer held", buf_empty, 0);
        end
        if (hold_tick) tick = 1'b0;
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        if (hold_tick) begin
            repeat (30) @(negedge clk);
            chk(cec_drive_low == 1'b0, "R3 no drive before tick", cec_drive_low, 0);
            chk(tx_en == 1'b1, "R3 enable pending", tx_en, 1);
            tick = 1'b1;
            @(negedge clk); @(negedge clk);
            chk(cec_drive_low == 1'b1, "R3 start on first tick", cec_drive_low, 1);
        end
        for (int i = 1; i < n; i++) begin
            while (!buf_empty) @(negedge clk);
            wr_buf(fb[i], !am && i == n - 1 && last_eom);
        end
        guard = 0;
        while (tx_en && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(tx_en == 1'b0, "R10 enable cleared", tx_en, 0);
        repeat (500) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all symbols sent", exp_q.size(), 0);
        chk(ack_seen == ack_plan[n - 1], "R9 ack sample", ack_seen, ack_plan[n - 1]);
        chk(irq_cnt == n * (int'(e8) + int'(e10)), "R6 R7 irq count", irq_cnt,
            n * (int'(e8) + int'(e10)));
        chk(flag8 == 1'b1, "R6 flag8 set", flag8, 1);
        chk(flag_tx == 1'b1, "R7 flag_tx set", flag_tx, 1);
        chk(buf_empty == 1'b1, "R5 empty after frame", buf_empty, 1);
        @(negedge clk); flag8_clr = 1'b1; flagtx_clr = 1'b1;
        @(negedge clk); flag8_clr = 1'b0; flagtx_clr = 1'b0;
        chk(flag8 == 1'b0, "R8 flag8 cleared", flag8, 0);
        chk(flag_tx == 1'b0, "R8 flag_tx cleared", flag_tx, 0);
    endtask

    initial begin
        logic [7:0] fb[8];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cec_drive_low == 1'b0, "R11 drive", cec_drive_low, 0);
        chk(tx_en == 1'b0, "R11 tx_en", tx_en, 0);
        chk(buf_empty == 1'b1, "R11 buf_empty", buf_empty, 1);
        chk(flag8 == 1'b0 && flag_tx == 1'b0, "R11 flags", flag8 | flag_tx, 0);
        chk(ack_seen == 1'b0 && irq == 1'b0, "R11 ack/irq", ack_seen | irq, 0);

        // Frame A: automatic EOM (R4), two blocks, all acknowledged, tick held (R3)
        fb[0] = 8'hA5; fb[1] = 8'h3C;
        ack_plan[0] = 1; ack_plan[1] = 1;
        run_frame(fb, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

        // Frame B: automatic EOM, header only, no follower, ignored overwrite (R5, R9)
        fb[0] = 8'h0F; ack_plan[0] = 0;
        run_frame(fb, 1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);

        // Frame C: manual EOM (R4), three blocks, mixed acknowledges, both irqs
        fb[0] = 8'h81; fb[1] = 8'h00; fb[2] = 8'hFF;
        ack_plan[0] = 1; ack_plan[1] = 0; ack_plan[2] = 1;
        run_frame(fb, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // Frame D: manual EOM 0 and no next byte: underrun ends frame (R10)
        fb[0] = 8'h44; ack_plan[0] = 0;
        run_frame(fb, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(cec_drive_low == 1'b0, "R10 line released", cec_drive_low, 0);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

endmodule